// File: doc/BRIEF.md
# Banked GPIO Port Register Set

This block is the general-purpose I/O function that sits behind one logical-device bank of a configuration port. The bank holds two ports of up to eight pins each. Each port has three registers: one that sets the direction of every pin, one that carries the data, and one that can invert each pin. A shared register in the bank holds one enable bit for each port. The second port can be built with fewer pins; the default build gives it five. A host reaches every register through a plain register bus with an address, write data, a write strobe and combinational read data.

The choice between push-pull and open-drain drive does not come from the bank. It arrives on an input, one bit per port, from a global register elsewhere in the chip. A two-bit pin-function code decides whether the first port's pins belong to this logic or to another function. The block produces an output-enable and an output value for every pad. Before any pad input can be read, it passes through a two-stage synchronizer.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset both enable bits are 0. Each port's direction register reads all ones on its implemented pins (every pin is an input), and its data latch and inversion register are 0. Every pad output-enable is 0.
- R2: Bank offset 0x30 holds the enable bits: bit EN_BIT_A (default 0) for the first port and bit EN_BIT_B (default 1) for the second. All other bits of that register read 0.
- R3: The first port's registers sit at 0xE0 (direction), 0xE1 (data) and 0xE2 (inversion). The second port's sit at 0xE4, 0xE5 and 0xE6. The direction and inversion registers read back what was written. Any address outside the map reads 0.
- R4: A direction bit of 1 makes its pin an input and a 0 makes it an output. In push-pull mode, an enabled and routed port asserts output-enable on exactly its output pins.
- R5: Each pad output value is the data latch XOR the inversion bit. A write to the data register changes only the latch.
- R6: When a port's push-pull select bit is 0 (open drain), an output pin asserts output-enable only while its output value is 0. When the bit is 1, the pin drives both levels. Select bit 0 belongs to the first port and bit 1 to the second.
- R7: A read of the data register returns, on each pin, the synchronized pad level for an input pin or the latch for an output pin, XORed with that pin's inversion bit.
- R8: While a port's enable bit is 0, all of its output-enables are 0 and its data register reads 0.
- R9: Pin-function code 2 hands the first port's pins to this logic. Codes 0, 1 and 3 give them to other functions: while one of those codes is applied, the first port asserts no output-enable and its input pins are taken as low.
- R10: On the short port, the pins at or above B_PINS read 0 in all three registers, ignore writes, and keep output-enable and output value at 0.
- R11: A pad input change can be seen in a data read only after two rising clock edges. After one edge the read still shows the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address within the bank |
| reg_wdata | input | W | Write data |
| reg_wr | input | 1 | Write strobe, takes effect at the rising edge |
| reg_rdata | output | W | Combinational read data for reg_addr |
| drv_pp | input | 2 | Push-pull select per port from a global register (1 = push-pull) |
| pin_func | input | 2 | Function code for the first port's pins (2 = GPIO) |
| a_pad_in | input | W | First port pad input levels |
| a_pad_oe | output | W | First port pad output-enables |
| a_pad_out | output | W | First port pad output values |
| b_pad_in | input | W | Second port pad input levels |
| b_pad_oe | output | W | Second port pad output-enables |
| b_pad_out | output | W | Second port pad output values |

## Verification
The assertions take for granted that drv_pp and pin_func are steady, well-defined levels sampled at the clock, and that the read address is stable whenever reg_rdata is checked against the map. The stimulus changes pads, drive-mode and function-code inputs only on falling edges, and it holds them steady until every result that depends on them has been sampled. Reads are issued with the write strobe low, so no read result depends on a register updating in the same cycle. Pad inputs above the short port's width are driven high on purpose to show they are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int AW          = 8;
   localparam int BANK_PORTS  = 2;
   localparam int PORT_BASE   = 'hE0;
   localparam int PORT_STRIDE = 4;

   localparam logic [AW-1:0] ADDR_ENABLE = 8'h30;

   // Register slot within one port's window.
   localparam int OFS_DIR  = 0;
   localparam int OFS_DATA = 1;
   localparam int OFS_INV  = 2;

   typedef enum logic [1:0] {
      PF_IR_OFF = 2'd0,
      PF_IR     = 2'd1,
      PF_GPIO   = 2'd2,
      PF_UART   = 2'd3
   } pin_func_e;

   function automatic logic [AW-1:0] port_reg_addr(input int port, input int slot);
      return AW'(PORT_BASE + port * PORT_STRIDE + slot);
   endfunction

   function automatic logic addr_in_map(input logic [AW-1:0] a);
      logic hit;
      hit = (a == ADDR_ENABLE);
      for (int p = 0; p < BANK_PORTS; p++) begin
         for (int s = OFS_DIR; s <= OFS_INV; s++) begin
            if (a == port_reg_addr(p, s)) hit = 1'b1;
         end
      end
      return hit;
   endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         q        <= '0;
      end else begin
         stage1_q <= d;
         q        <= stage1_q;
      end
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int W    = 8,
   parameter int PINS = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_dir,
   input  logic         wr_dat,
   input  logic         wr_inv,
   input  logic [W-1:0] wdata,
   input  logic         en,
   input  logic         pp,
   input  logic         route,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] dir_rd,
   output logic [W-1:0] dat_rd,
   output logic [W-1:0] inv_rd,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out
);

   function automatic logic [W-1:0] build_mask();
      logic [W-1:0] m;
      for (int i = 0; i < W; i++) m[i] = (i < PINS);
      return m;
   endfunction

   localparam logic [W-1:0] PIN_MASK = build_mask();

   logic [W-1:0] dir_q;
   logic [W-1:0] lat_q;
   logic [W-1:0] inv_q;
   logic [W-1:0] drive_val;
   logic [W-1:0] pin_seen;
   logic [W-1:0] out_pins;
   logic [W-1:0] drive_ok;
   logic         live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= PIN_MASK;
         lat_q <= '0;
         inv_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wdata & PIN_MASK;
         if (wr_dat) lat_q <= wdata & PIN_MASK;
         if (wr_inv) inv_q <= wdata & PIN_MASK;
      end
   end

   assign live      = en && route;
   assign drive_val = (lat_q ^ inv_q) & PIN_MASK;
   assign pin_seen  = route ? (pin_in & PIN_MASK) : '0;
   assign out_pins  = ~dir_q & PIN_MASK;
   // Open drain drives only the low level.
   assign drive_ok  = pp ? PIN_MASK : ~drive_val;

   assign pad_out = drive_val;
   assign pad_oe  = live ? (out_pins & drive_ok) : '0;

   assign dat_rd = en ? ((((dir_q & pin_seen) | (out_pins & lat_q)) ^ inv_q) & PIN_MASK) : '0;
   assign dir_rd = dir_q;
   assign inv_rd = inv_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int W        = 8,
   parameter int A_PINS   = 8,
   parameter int B_PINS   = 5,
   parameter int EN_BIT_A = 0,
   parameter int EN_BIT_B = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic [W-1:0]  reg_wdata,
   input  logic          reg_wr,
   output logic [W-1:0]  reg_rdata,
   input  logic [1:0]    drv_pp,
   input  logic [1:0]    pin_func,
   input  logic [W-1:0]  a_pad_in,
   output logic [W-1:0]  a_pad_oe,
   output logic [W-1:0]  a_pad_out,
   input  logic [W-1:0]  b_pad_in,
   output logic [W-1:0]  b_pad_oe,
   output logic [W-1:0]  b_pad_out
);

   localparam int NP = BANK_PORTS;

   if (A_PINS < 1 || A_PINS > W) begin : g_bad_a_pins
      $error("A_PINS must lie in 1..W");
   end
   if (B_PINS < 1 || B_PINS > W) begin : g_bad_b_pins
      $error("B_PINS must lie in 1..W");
   end
   if (EN_BIT_A == EN_BIT_B || EN_BIT_A >= W || EN_BIT_B >= W) begin : g_bad_en_bits
      $error("enable bit positions must differ and fit in W");
   end

   logic [NP-1:0]   en_q;
   logic [NP-1:0]   wr_dir;
   logic [NP-1:0]   wr_dat;
   logic [NP-1:0]   wr_inv;
   logic [NP*W-1:0] sync_flat;
   logic [W-1:0]    dir_rd [NP];
   logic [W-1:0]    dat_rd [NP];
   logic [W-1:0]    inv_rd [NP];
   logic [W-1:0]    oe_v   [NP];
   logic [W-1:0]    out_v  [NP];

   gpio_sync2 #(.W(NP * W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({b_pad_in, a_pad_in}),
      .q     (sync_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (reg_wr && reg_addr == ADDR_ENABLE) begin
         en_q[0] <= reg_wdata[EN_BIT_A];
         en_q[1] <= reg_wdata[EN_BIT_B];
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_port
      localparam int PINS = (p == 0) ? A_PINS : B_PINS;
      logic route;

      if (p == 0) begin : g_func_mux
         assign route = (pin_func == PF_GPIO);
      end else begin : g_fixed
         assign route = 1'b1;
      end

      assign wr_dir[p] = reg_wr && (reg_addr == port_reg_addr(p, OFS_DIR));
      assign wr_dat[p] = reg_wr && (reg_addr == port_reg_addr(p, OFS_DATA));
      assign wr_inv[p] = reg_wr && (reg_addr == port_reg_addr(p, OFS_INV));

      gpio_port #(.W(W), .PINS(PINS)) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_dir  (wr_dir[p]),
         .wr_dat  (wr_dat[p]),
         .wr_inv  (wr_inv[p]),
         .wdata   (reg_wdata),
         .en      (en_q[p]),
         .pp      (drv_pp[p]),
         .route   (route),
         .pin_in  (sync_flat[p*W +: W]),
         .dir_rd  (dir_rd[p]),
         .dat_rd  (dat_rd[p]),
         .inv_rd  (inv_rd[p]),
         .pad_oe  (oe_v[p]),
         .pad_out (out_v[p])
      );
   end

   assign a_pad_oe  = oe_v[0];
   assign a_pad_out = out_v[0];
   assign b_pad_oe  = oe_v[1];
   assign b_pad_out = out_v[1];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_ENABLE) begin
         reg_rdata[EN_BIT_A] = en_q[0];
         reg_rdata[EN_BIT_B] = en_q[1];
      end
      for (int p = 0; p < NP; p++) begin
         if (reg_addr == port_reg_addr(p, OFS_DIR))  reg_rdata = dir_rd[p];
         if (reg_addr == port_reg_addr(p, OFS_DATA)) reg_rdata = dat_rd[p];
         if (reg_addr == port_reg_addr(p, OFS_INV))  reg_rdata = inv_rd[p];
      end
   end

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
   import gpio_bank_pkg::*;
#(
   parameter int W        = 8,
   parameter int B_PINS   = 5,
   parameter int EN_BIT_A = 0,
   parameter int EN_BIT_B = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] reg_addr,
   input logic [W-1:0]  reg_wdata,
   input logic          reg_wr,
   input logic [W-1:0]  reg_rdata,
   input logic [1:0]    drv_pp,
   input logic [1:0]    pin_func,
   input logic [W-1:0]  a_pad_oe,
   input logic [W-1:0]  a_pad_out,
   input logic [W-1:0]  b_pad_oe,
   input logic [W-1:0]  b_pad_out
);

   function automatic logic [W-1:0] short_mask();
      logic [W-1:0] m;
      for (int i = 0; i < W; i++) m[i] = (i < B_PINS);
      return m;
   endfunction

   localparam logic [W-1:0] B_MASK = short_mask();
   localparam logic [W-1:0] EN_MASK = (W'(1) << EN_BIT_A) | (W'(1) << EN_BIT_B);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (a_pad_oe == '0 && b_pad_oe == '0));

   assert_enable_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_ENABLE) |-> ((reg_rdata & ~EN_MASK) == '0));

   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_in_map(reg_addr) |-> (reg_rdata == '0));

   assert_od_a_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_pp[0] |-> ((a_pad_oe & a_pad_out) == '0));

   assert_od_b_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_pp[1] |-> ((b_pad_oe & b_pad_out) == '0));

   assert_disable_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_ENABLE && !reg_wdata[EN_BIT_A]) |=> (a_pad_oe == '0));

   assert_disable_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_ENABLE && !reg_wdata[EN_BIT_B]) |=> (b_pad_oe == '0));

   assert_func_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_func != PF_GPIO) |-> (a_pad_oe == '0));

   assert_short_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((b_pad_oe | b_pad_out) & ~B_MASK) == '0);

endmodule

bind gpio_bank_regs gpio_bank_checker #(
   .W        (W),
   .B_PINS   (B_PINS),
   .EN_BIT_A (EN_BIT_A),
   .EN_BIT_B (EN_BIT_B)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata),
   .drv_pp    (drv_pp),
   .pin_func  (pin_func),
   .a_pad_oe  (a_pad_oe),
   .a_pad_out (a_pad_out),
   .b_pad_oe  (b_pad_oe),
   .b_pad_out (b_pad_out)
);

// File: tb/gpio_bank_regs_test.sv
`timescale 1ns/1ps
module gpio_bank_regs_test;

   localparam int K_RD  = 0;
   localparam int K_AOE = 1;
   localparam int K_AO  = 2;
   localparam int K_BOE = 3;
   localparam int K_BO  = 4;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;
   logic [1:0] drv_pp = 2'b11;
   logic [1:0] pin_func = 2'd2;
   logic [7:0] a_pad_in = 8'h00;
   logic [7:0] a_pad_oe;
   logic [7:0] a_pad_out;
   logic [7:0] b_pad_in = 8'h00;
   logic [7:0] b_pad_oe;
   logic [7:0] b_pad_out;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   item_t sb[$];
   item_t mon_it;
   logic [7:0] act;
   event  item_ev;

   gpio_bank_regs uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rdata (reg_rdata),
      .drv_pp    (drv_pp),
      .pin_func  (pin_func),
      .a_pad_in  (a_pad_in),
      .a_pad_oe  (a_pad_oe),
      .a_pad_out (a_pad_out),
      .b_pad_in  (b_pad_in),
      .b_pad_oe  (b_pad_oe),
      .b_pad_out (b_pad_out)
   );

   always #2.5 clk = ~clk;

   // Monitor: pops each expected item and compares it with the design.
   initial begin
      forever begin
         @(item_ev);
         #1;
         while (sb.size() > 0) begin
            mon_it = sb.pop_front();
            case (mon_it.kind)
               K_AOE:   act = a_pad_oe;
               K_AO:    act = a_pad_out;
               K_BOE:   act = b_pad_oe;
               K_BO:    act = b_pad_out;
               default: act = reg_rdata;
            endcase
            n_checks++;
            if (act !== mon_it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", mon_it.req, act, mon_it.exp);
            end
         end
      end
   end

   task automatic expect_item(input int kind, input logic [7:0] addr,
                              input logic [7:0] exp, input string req);
      item_t it;
      @(negedge clk);
      reg_addr = addr;
      #1;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      sb.push_back(it);
      -> item_ev;
   endtask

   task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
      @(negedge clk);
      reg_addr  = addr;
      reg_wdata = data;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_item(K_RD,  8'h30, 8'h00, "R1 enable reset");
      expect_item(K_RD,  8'hE0, 8'hFF, "R1 dir A reset");
      expect_item(K_RD,  8'hE4, 8'h1F, "R1 dir B reset");
      expect_item(K_RD,  8'hE2, 8'h00, "R1 inv A reset");
      expect_item(K_AOE, 8'h00, 8'h00, "R1 oe A reset");
      expect_item(K_BOE, 8'h00, 8'h00, "R1 oe B reset");

      // R2 enable register
      bus_write(8'h30, 8'hFF);
      expect_item(K_RD, 8'h30, 8'h03, "R2 enable bits only");

      // R3 map, readback, unmapped
      bus_write(8'hE2, 8'hA5);
      expect_item(K_RD, 8'hE2, 8'hA5, "R3 inv A readback");
      bus_write(8'hE6, 8'hFF);
      expect_item(K_RD, 8'hE6, 8'h1F, "R3 R10 inv B readback short");
      expect_item(K_RD, 8'h55, 8'h00, "R3 unmapped read");
      expect_item(K_RD, 8'hE3, 8'h00, "R3 gap read");
      bus_write(8'hE2, 8'h00);
      bus_write(8'hE6, 8'h00);

      // R4 direction, R5 output value
      bus_write(8'hE0, 8'hF0);
      bus_write(8'hE1, 8'h0A);
      expect_item(K_AOE, 8'h00, 8'h0F, "R4 oe on output pins");
      expect_item(K_AO,  8'h00, 8'h0A, "R5 pad out no inversion");
      expect_item(K_RD,  8'hE1, 8'h0A, "R7 data read outputs");
      bus_write(8'hE2, 8'h03);
      expect_item(K_AO,  8'h00, 8'h09, "R5 pad out inverted");
      expect_item(K_RD,  8'hE1, 8'h09, "R7 read with inversion");
      expect_item(K_RD,  8'hE0, 8'hF0, "R5 data write left dir unchanged");

      // R6 open drain on the first port
      @(negedge clk);
      drv_pp = 2'b10;
      expect_item(K_AOE, 8'h00, 8'h06, "R6 open drain drives low only");
      @(negedge clk);
      drv_pp = 2'b11;
      expect_item(K_AOE, 8'h00, 8'h0F, "R6 push-pull drives both");
      bus_write(8'hE2, 8'h00);

      // R11 synchronizer latency, R7 input read
      @(negedge clk);
      a_pad_in = 8'h50;
      expect_item(K_RD, 8'hE1, 8'h0A, "R11 one edge old level");
      expect_item(K_RD, 8'hE1, 8'h5A, "R11 R7 two edges new level");
      bus_write(8'hE2, 8'hF0);
      expect_item(K_RD, 8'hE1, 8'hAA, "R7 inputs inverted");
      bus_write(8'hE2, 8'h00);

      // R9 pin function select
      @(negedge clk);
      pin_func = 2'd1;
      expect_item(K_AOE, 8'h00, 8'h00, "R9 code 1 releases pins");
      expect_item(K_RD,  8'hE1, 8'h0A, "R9 inputs taken low");
      @(negedge clk);
      pin_func = 2'd3;
      expect_item(K_AOE, 8'h00, 8'h00, "R9 code 3 releases pins");
      @(negedge clk);
      pin_func = 2'd2;
      expect_item(K_AOE, 8'h00, 8'h0F, "R9 code 2 routes pins");

      // R8 disable first port
      bus_write(8'h30, 8'h02);
      expect_item(K_AOE, 8'h00, 8'h00, "R8 disabled port no oe");
      expect_item(K_RD,  8'hE1, 8'h00, "R8 disabled port reads 0");

      // R10 short port
      bus_write(8'hE4, 8'h00);
      expect_item(K_RD,  8'hE4, 8'h00, "R10 dir B written");
      bus_write(8'hE5, 8'hFF);
      expect_item(K_BO,  8'h00, 8'h1F, "R10 out B masked");
      expect_item(K_BOE, 8'h00, 8'h1F, "R10 oe B masked");
      expect_item(K_RD,  8'hE5, 8'h1F, "R10 data B masked");
      bus_write(8'hE4, 8'hFF);
      @(negedge clk);
      b_pad_in = 8'hE0;
      @(negedge clk);
      @(negedge clk);
      expect_item(K_RD,  8'hE5, 8'h00, "R10 high pads ignored");
      expect_item(K_BOE, 8'h00, 8'h00, "R4 inputs no oe");

      // R8 disable second port
      bus_write(8'hE4, 8'h00);
      bus_write(8'h30, 8'h00);
      expect_item(K_BOE, 8'h00, 8'h00, "R8 port B disabled");
      expect_item(K_RD,  8'h30, 8'h00, "R2 enables cleared");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule